// File: doc/BRIEF.md
# Chip-Selected Serial Byte Receiver

This block is the serial input path of a display controller. A host shifts command or display bytes in over one data line and one clock line while holding an active-low chip select. Inside the serial clock domain an 8-bit shift register collects the bits, most significant first, and a 3-bit counter marks the end of each byte. The counter wraps after every eighth edge, so bytes can stream back to back without deselecting the chip.

On every eighth rising serial clock edge the finished byte is latched together with a tag taken from the A0 input at that same edge. A0 high marks display data and A0 low marks a command. Completion is signalled by flipping a toggle flag. The system clock domain synchronizes that flag, detects its edge and presents the byte with a one-cycle valid pulse. Raising chip select clears the shift register and the counter at once, so any partial byte is dropped.

Top module: `sr_serial_byte_rx`

## Requirements
- R1: While `rst_n` is low, `byte_valid`, `byte_data` and `byte_is_data` are all 0.
- R2: Bits are taken from `sdi` on rising `sclk` edges while `cs_n` is low. The first bit of a byte lands in `byte_data[7]` and the eighth lands in `byte_data[0]`.
- R3: Each completed byte produces exactly one `byte_valid` pulse, one `clk` cycle wide.
- R4: `byte_is_data` equals the level of `a0` at the eighth rising `sclk` edge of the byte (1 = display data, 0 = command). The level of `a0` at the other seven edges has no effect.
- R5: The bit counter wraps from 7 to 0, so consecutive bytes sent under one continuous selection are each delivered, in order.
- R6: Raising `cs_n` clears the shift register and the counter. A partial byte cut off this way produces no pulse, and the first edge after reselection starts a new byte at bit 7.
- R7: `sclk` edges while `cs_n` is high produce no pulse and do not shift any bits into the next byte.
- R8: `byte_data` and `byte_is_data` change only in a cycle where `byte_valid` is high, and they hold their value between pulses.
- R9: `byte_valid` rises no more than SYNC_STAGES+2 `clk` cycles after the eighth `sclk` edge of the byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low chip select; high clears the serial state |
| sclk | input | 1 | Serial clock; bits are sampled on its rising edge |
| sdi | input | 1 | Serial data input, MSB first |
| a0 | input | 1 | Command/data marker, sampled on the last edge of each byte |
| byte_valid | output | 1 | One-cycle pulse per received byte |
| byte_data | output | WORD_W | Received byte |
| byte_is_data | output | 1 | 1 = display data, 0 = command |

## Verification
The assertions assume that `sclk` runs much slower than `clk`. At least SYNC_STAGES+2 system cycles must separate two byte completions, so the held byte is stable whenever the synchronized toggle is seen. They also assume that `cs_n` and `sclk` never change at a `clk` edge. The stimulus meets these conditions by driving every serial edge one nanosecond after a falling `clk` edge, with a serial period of eight system cycles. It also changes `cs_n` only between serial edges, with the serial clock low.

// File: rtl/sr_rx_pkg.sv
package sr_rx_pkg;

   typedef enum logic {
      TAG_CMD  = 1'b0,
      TAG_DATA = 1'b1
   } sr_tag_e;

   function automatic int unsigned cnt_width(input int unsigned n);
      return (n <= 2) ? 1 : $clog2(n);
   endfunction

endpackage

// File: rtl/sr_rx_shift.sv
module sr_rx_shift
   import sr_rx_pkg::*;
#(
   parameter int unsigned WORD_W = 8,
   parameter int unsigned CNT_W  = 3
) (
   input  logic              sclk,
   input  logic              cs_n,
   input  logic              rst_n,
   input  logic              sdi,
   input  logic              a0,
   output logic [WORD_W-1:0] hold_data,
   output sr_tag_e           hold_tag,
   output logic              done_tog,
   output logic [CNT_W-1:0]  bit_cnt
);

   localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

   logic [WORD_W-1:0] shift_q;
   logic [WORD_W-1:0] word_full;
   logic              at_last;

   assign word_full = {shift_q[WORD_W-2:0], sdi};
   assign at_last   = (bit_cnt == LAST);

   // serial state: cleared asynchronously while deselected
   always_ff @(posedge sclk or posedge cs_n) begin
      if (cs_n) begin
         shift_q <= '0;
         bit_cnt <= '0;
      end else begin
         shift_q <= word_full;
         bit_cnt <= at_last ? '0 : bit_cnt + 1'b1;
      end
   end

   // completed-byte holding register and handoff flag
   always_ff @(posedge sclk or negedge rst_n) begin
      if (!rst_n) begin
         hold_data <= '0;
         hold_tag  <= TAG_CMD;
         done_tog  <= 1'b0;
      end else if (!cs_n && at_last) begin
         hold_data <= word_full;
         hold_tag  <= a0 ? TAG_DATA : TAG_CMD;
         done_tog  <= ~done_tog;
      end
   end

endmodule

// File: rtl/sr_rx_sync.sv
module sr_rx_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tog_in,
   output logic pulse
);

   logic [STAGES-1:0] chain;
   logic              last_q;

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[0] <= 1'b0;
            else        chain[0] <= tog_in;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[i] <= 1'b0;
            else        chain[i] <= chain[i-1];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) last_q <= 1'b0;
      else        last_q <= chain[STAGES-1];
   end

   assign pulse = chain[STAGES-1] ^ last_q;

endmodule

// File: rtl/sr_rx_out.sv
module sr_rx_out
   import sr_rx_pkg::*;
#(
   parameter int unsigned WORD_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              take,
   input  logic [WORD_W-1:0] hold_data,
   input  sr_tag_e           hold_tag,
   output logic              byte_valid,
   output logic [WORD_W-1:0] byte_data,
   output logic              byte_is_data
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         byte_valid   <= 1'b0;
         byte_data    <= '0;
         byte_is_data <= 1'b0;
      end else begin
         byte_valid <= take;
         if (take) begin
            byte_data    <= hold_data;
            byte_is_data <= (hold_tag == TAG_DATA);
         end
      end
   end

endmodule

// File: rtl/sr_serial_byte_rx.sv
module sr_serial_byte_rx
   import sr_rx_pkg::*;
#(
   parameter int unsigned WORD_W      = 8,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_n,
   input  logic              sclk,
   input  logic              sdi,
   input  logic              a0,
   output logic              byte_valid,
   output logic [WORD_W-1:0] byte_data,
   output logic              byte_is_data
);

   localparam int unsigned CNT_W = cnt_width(WORD_W);

   if (WORD_W < 2) begin : g_bad_width
      $error("sr_serial_byte_rx: WORD_W must be at least 2");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("sr_serial_byte_rx: SYNC_STAGES must be at least 2");
   end

   logic [WORD_W-1:0] hold_data;
   sr_tag_e           hold_tag;
   logic              done_tog;
   logic [CNT_W-1:0]  bit_cnt;
   logic              take;

   sr_rx_shift #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_shift (
      .sclk      (sclk),
      .cs_n      (cs_n),
      .rst_n     (rst_n),
      .sdi       (sdi),
      .a0        (a0),
      .hold_data (hold_data),
      .hold_tag  (hold_tag),
      .done_tog  (done_tog),
      .bit_cnt   (bit_cnt)
   );

   sr_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .tog_in (done_tog),
      .pulse  (take)
   );

   sr_rx_out #(.WORD_W(WORD_W)) u_out (
      .clk          (clk),
      .rst_n        (rst_n),
      .take         (take),
      .hold_data    (hold_data),
      .hold_tag     (hold_tag),
      .byte_valid   (byte_valid),
      .byte_data    (byte_data),
      .byte_is_data (byte_is_data)
   );

endmodule

// File: rtl/sr_rx_chk.sv
module sr_rx_chk #(
   parameter int unsigned WORD_W = 8,
   parameter int unsigned CNT_W  = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cs_n,
   input logic              sclk,
   input logic              byte_valid,
   input logic [WORD_W-1:0] byte_data,
   input logic              byte_is_data,
   input logic              done_tog,
   input logic [CNT_W-1:0]  bit_cnt
);

   always_comb begin
      if (!rst_n) begin
         assert_reset_quiet_R1: assert (!byte_valid && byte_data == '0 && !byte_is_data);
      end
   end

   assert_single_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
      byte_valid |=> !byte_valid);

   assert_hold_output_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ((byte_data != $past(byte_data)) || (byte_is_data != $past(byte_is_data))) |-> byte_valid);

   assert_deselect_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n |-> (bit_cnt == '0));

   assert_wrap_after_byte_R5: assert property (@(posedge sclk) disable iff (!rst_n)
      (done_tog != $past(done_tog)) |-> (bit_cnt == '0));

endmodule

bind sr_serial_byte_rx sr_rx_chk #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .cs_n         (cs_n),
   .sclk         (sclk),
   .byte_valid   (byte_valid),
   .byte_data    (byte_data),
   .byte_is_data (byte_is_data),
   .done_tog     (done_tog),
   .bit_cnt      (bit_cnt)
);

// File: tb/sim_sr_serial_byte_rx.sv
`timescale 1ns/1ps
module sim_sr_serial_byte_rx;

   localparam int SYNC = 2;
   localparam int LAT  = SYNC + 2;

   logic       clk = 1'b0;
   logic       rst_n;
   logic       cs_n, sclk, sdi, a0;
   logic       byte_valid;
   logic [7:0] byte_data;
   logic       byte_is_data;

   int tests = 0;
   int fails = 0;
   int cyc = 0;
   int pulses = 0;
   bit run = 0;

   // reference model state
   logic [7:0] m_bits;
   int         m_n;
   logic [8:0] exp_q[$];
   int         exp_t[$];
   logic [7:0] last_data = '0;
   logic       last_tag = 1'b0;
   logic       prev_valid = 1'b0;

   always #2.5 clk = ~clk;

   sr_serial_byte_rx #(.WORD_W(8), .SYNC_STAGES(SYNC)) u0 (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdi(sdi), .a0(a0),
      .byte_valid(byte_valid), .byte_data(byte_data), .byte_is_data(byte_is_data)
   );

   always @(posedge clk) cyc <= cyc + 1;

   always @(posedge cs_n) begin
      m_n    = 0;
      m_bits = '0;
   end

   always @(posedge sclk) begin
      if (cs_n === 1'b0) begin
         m_bits = {m_bits[6:0], sdi};
         m_n    = m_n + 1;
         if (m_n == 8) begin
            exp_q.push_back({a0, m_bits});
            exp_t.push_back(cyc);
            m_n = 0;
         end
      end
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (run) begin
         if (byte_valid) begin
            pulses++;
            check(!prev_valid, "R3 pulse width", 1, 0);
            if (exp_q.size() == 0) begin
               check(0, "R6/R7 unexpected byte", byte_data, 0);
            end else begin
               logic [8:0] e;
               int t;
               e = exp_q.pop_front();
               t = exp_t.pop_front();
               check(byte_data == e[7:0], "R2 byte value", byte_data, e[7:0]);
               check(byte_is_data == e[8], "R4 tag", byte_is_data, e[8]);
               check(cyc - t <= LAT, "R9 latency", cyc - t, LAT);
            end
            last_data = byte_data;
            last_tag  = byte_is_data;
         end else begin
            if (byte_data != last_data || byte_is_data != last_tag)
               check(0, "R8 output hold", {byte_is_data, byte_data}, {last_tag, last_data});
            if (exp_t.size() != 0 && cyc - exp_t[0] > LAT) begin
               check(0, "R9 missing pulse", cyc - exp_t[0], LAT);
               void'(exp_q.pop_front());
               void'(exp_t.pop_front());
            end
         end
         prev_valid = byte_valid;
      end
   end

   task automatic send_bit(input logic b, input logic a);
      @(negedge clk);
      sdi = b;
      a0  = a;
      repeat (3) @(negedge clk);
      #1 sclk = 1'b1;
      repeat (4) @(negedge clk);
      #1 sclk = 1'b0;
   endtask

   // a0 is the inverse of the tag on the first seven edges (R4 ignore check)
   task automatic send_byte(input logic [7:0] v, input logic tag);
      for (int i = 7; i >= 0; i--) send_bit(v[i], (i == 0) ? tag : ~tag);
   endtask

   task automatic set_cs(input logic v);
      repeat (2) @(negedge clk);
      #1 cs_n = v;
      repeat (2) @(negedge clk);
   endtask

   task automatic drain;
      repeat (LAT + 6) @(negedge clk);
   endtask

   task automatic expect_pulses(input int n0, input int add, input string req);
      check(pulses == n0 + add, req, pulses - n0, add);
   endtask

   initial begin
      int p0;
      rst_n = 1'b0; cs_n = 1'b1; sclk = 1'b0; sdi = 1'b0; a0 = 1'b0;
      repeat (4) @(negedge clk);
      check(byte_valid == 1'b0, "R1 valid in reset", byte_valid, 0);
      check(byte_data == 8'h00, "R1 data in reset", byte_data, 0);
      check(byte_is_data == 1'b0, "R1 tag in reset", byte_is_data, 0);
      @(negedge clk); #1 rst_n = 1'b1;
      run = 1;
      repeat (3) @(negedge clk);

      // R2 R4: one command byte, one display byte
      p0 = pulses;
      set_cs(1'b0);
      send_byte(8'hA5, 1'b0);
      drain;
      expect_pulses(p0, 1, "R3 command byte count");
      check(byte_is_data == 1'b0, "R4 command tag", byte_is_data, 0);
      set_cs(1'b1);
      set_cs(1'b0);
      send_byte(8'h3C, 1'b1);
      drain;
      check(byte_data == 8'h3C, "R2 display byte", byte_data, 8'h3C);
      check(byte_is_data == 1'b1, "R4 display tag", byte_is_data, 1);
      set_cs(1'b1);

      // R5: streaming bytes without deselect
      p0 = pulses;
      set_cs(1'b0);
      send_byte(8'h01, 1'b1);
      send_byte(8'h80, 1'b0);
      send_byte(8'hFF, 1'b1);
      send_byte(8'h5A, 1'b0);
      drain;
      expect_pulses(p0, 4, "R5 streamed byte count");
      set_cs(1'b1);

      // R6: partial byte dropped, next byte aligned
      p0 = pulses;
      set_cs(1'b0);
      for (int i = 0; i < 5; i++) send_bit(1'b1, 1'b1);
      set_cs(1'b1);
      drain;
      expect_pulses(p0, 0, "R6 partial byte dropped");
      set_cs(1'b0);
      send_byte(8'h12, 1'b0);
      drain;
      expect_pulses(p0, 1, "R6 byte after reselect");
      check(byte_data == 8'h12, "R6 realigned byte", byte_data, 8'h12);
      set_cs(1'b1);

      // R7: clocks while deselected
      p0 = pulses;
      for (int i = 0; i < 11; i++) send_bit(1'b1, 1'b1);
      drain;
      expect_pulses(p0, 0, "R7 no pulse while deselected");
      set_cs(1'b0);
      send_byte(8'h0F, 1'b1);
      drain;
      check(byte_data == 8'h0F, "R7 next byte unaffected", byte_data, 8'h0F);
      check(byte_is_data == 1'b1, "R4 tag after idle clocks", byte_is_data, 1);
      set_cs(1'b1);
      drain;

      check(exp_q.size() == 0, "R3 all bytes delivered", exp_q.size(), 0);
      run = 0;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      tests++;
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule